// File: doc/BRIEF.md
# Shared Pool Buffer Allocator

This block keeps the packet-buffer accounts for a group of four ports that draw on one common buffer memory, the way a sixteen-lane group of a switch shares its receive storage. Each port owns a guaranteed reserve whose size software sets. Every buffer not promised to a reserve belongs to a common pool. Ports ask for buffers one at a time and hand them back one at a time. The block answers each request one cycle later with a grant, marked with its source, or with a denial.

A port fills its own reserve first. Once its reserve use passes a programmable threshold, or once the reserve is full, it borrows from the common pool. If several ports want the pool in the same cycle, a round-robin arbiter gives out one pool buffer per cycle. A port that loses the arbitration, or finds the pool empty, falls back on its reserve if the reserve still has room. A release repays borrowed buffers first, so buffers go back to the pool as soon as the port's demand drops.

Configuration loads all minimums and thresholds in one strobe. The block takes a new configuration only when no port holds a buffer, and it flags a configuration that promises more buffers than the pool has. The packet memory itself and the flow-control messages built from these counts lie outside the block.

Top module: `sbuf_alloc_top`

## Requirements
- R1: After reset every occupancy reads 0, no grant, pool or deny bit is set, cfgErr is 0, every port's minimum is POOL_SIZE/8 (8 for the default of 64), its threshold field is 0, and poolFree reads POOL_SIZE minus the four minimums (32 by default).
- R2: poolFree always equals POOL_SIZE minus the sum of the four minimums minus the number of buffers currently borrowed from the pool.
- R3: An allocate request from a port whose reserve use is at or below its effective threshold and below its minimum is granted from the reserve: allocGrant bit set and allocFromPool bit clear in the cycle after the request, and that port's occupancy rises by one.
- R4: An allocate request from a port whose reserve use exceeds its effective threshold, or whose reserve is full, takes a pool buffer if poolFree is nonzero and the arbiter picks that port: allocGrant and allocFromPool both set in the next cycle.
- R5: At most one pool buffer is granted per cycle. The arbiter searches upward in port index from a pointer, wrapping from port 3 to port 0. The pointer starts at port 0 and moves to the port after the last pool grantee.
- R6: A pool-seeking port that loses arbitration, or finds poolFree at 0, is granted from its reserve if its reserve use is below its minimum. Otherwise it gets allocDeny in the next cycle, and no count changes. Denied requests are not kept.
- R7: A release decrements the port's borrowed count if it is nonzero, and the reserve count otherwise. A release at zero occupancy does nothing. An allocate request in the same cycle as a release on the same port gets neither grant nor deny.
- R8: A threshold field of 0 selects an effective threshold of floor(minimum/4), which is 25 percent. Any other value is used as given.
- R9: A configuration strobe while any port holds a buffer is ignored: minimums, thresholds, poolFree and cfgErr stay as they were.
- R10: A configuration strobe taken while all ports are idle, whose minimums sum above POOL_SIZE, sets cfgErr and keeps the old configuration. A valid one loads the minimums and thresholds and clears cfgErr. In any cycle with the strobe high, all allocate and release requests are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfgLoad | input | 1 | Configuration strobe |
| cfgMinVec | input | 4*CNT_W | Per-port reserve minimum, port p in bits [p*CNT_W +: CNT_W] |
| cfgThrVec | input | 4*CNT_W | Per-port threshold field, same packing, 0 selects 25 percent |
| allocReq | input | 4 | Per-port request for one buffer |
| relReq | input | 4 | Per-port return of one buffer |
| allocGrant | output | 4 | Request of the previous cycle granted |
| allocFromPool | output | 4 | Granted buffer came from the common pool |
| allocDeny | output | 4 | Request of the previous cycle refused |
| occupancy | output | 4*CNT_W | Buffers held per port (reserve plus borrowed) |
| poolFree | output | CNT_W | Unreserved, unborrowed buffers left in the pool |
| cfgErr | output | 1 | Last accepted configuration attempt oversubscribed the pool |

## Verification
Single-port ramps separate reserve grants from pool grants at the threshold edge, under both the default 25 percent threshold and an explicit one. Simultaneous requests from all four ports after each has crossed its threshold show that the pool is handed out one buffer per cycle in rotation, while the losers fall back on their reserves. A configuration that reserves the whole pool drives ports into denial, and busy or oversubscribed configuration strobes test that state is left as it was. A long random mix of allocate, release and configuration traffic is compared against the reference model in every cycle.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;

  // Ports sharing one buffer memory (a sixteen-lane group)
  localparam int SB_PORTS = 4;

  // Strobes from the decision logic to the counters
  typedef struct packed {
    logic [SB_PORTS-1:0] takeOwn;
    logic [SB_PORTS-1:0] takePool;
    logic [SB_PORTS-1:0] giveOwn;
    logic [SB_PORTS-1:0] givePool;
    logic [SB_PORTS-1:0] deny;
    logic                cfgAccept;
    logic                cfgReject;
  } sbStrobe_t;

endpackage

// File: rtl/sbuf_ctrl.sv
module sbuf_ctrl
  import sbuf_pkg::*;
#(
  parameter int POOL_SIZE = 64,
  parameter int CNT_W     = 7
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               cfgLoad,
  input  logic [SB_PORTS*CNT_W-1:0]          cfgMinVec,
  input  logic [SB_PORTS-1:0]                allocReq,
  input  logic [SB_PORTS-1:0]                relReq,
  input  logic [SB_PORTS-1:0][CNT_W-1:0]     ownUsed,
  input  logic [SB_PORTS-1:0][CNT_W-1:0]     borrowed,
  input  logic [SB_PORTS-1:0][CNT_W-1:0]     minCnt,
  input  logic [SB_PORTS-1:0][CNT_W-1:0]     thrEff,
  input  logic [CNT_W-1:0]                   poolFree,
  input  logic                               idle,
  output sbStrobe_t                          strobe
);

  localparam int NP    = SB_PORTS;
  localparam int PW    = (NP > 1) ? $clog2(NP) : 1;
  localparam int SUM_W = CNT_W + PW + 1;

  logic [PW-1:0]    rrPtr;
  logic [PW-1:0]    winIdx;
  logic             winFound;
  logic [SUM_W-1:0] cfgSum;
  logic [NP-1:0]    req;
  logic [NP-1:0]    ownRoom;
  logic [NP-1:0]    wantPool;

  // Per-port request qualification
  for (genvar g = 0; g < NP; g++) begin : g_port
    assign req[g]      = allocReq[g] & ~relReq[g] & ~cfgLoad;
    assign ownRoom[g]  = ownUsed[g] < minCnt[g];
    assign wantPool[g] = req[g] & ((ownUsed[g] > thrEff[g]) | ~ownRoom[g]);
  end

  always_comb begin
    cfgSum = '0;
    for (int p = 0; p < NP; p++) begin
      cfgSum = cfgSum + SUM_W'(cfgMinVec[p*CNT_W +: CNT_W]);
    end
  end

  // Round-robin search for the single pool grant of this cycle
  always_comb begin
    logic [PW-1:0] cand;
    winFound = 1'b0;
    winIdx   = rrPtr;
    for (int i = 0; i < NP; i++) begin
      cand = PW'(rrPtr + PW'(i));
      if (!winFound && wantPool[cand] && (poolFree != '0)) begin
        winFound = 1'b1;
        winIdx   = cand;
      end
    end
  end

  always_comb begin
    strobe = '0;
    strobe.cfgAccept = cfgLoad & idle & (cfgSum <= SUM_W'(POOL_SIZE));
    strobe.cfgReject = cfgLoad & idle & (cfgSum >  SUM_W'(POOL_SIZE));
    for (int p = 0; p < NP; p++) begin
      if (req[p]) begin
        if (winFound && (winIdx == PW'(p))) strobe.takePool[p] = 1'b1;
        else if (ownRoom[p])                strobe.takeOwn[p]  = 1'b1;
        else                                strobe.deny[p]     = 1'b1;
      end
      if (relReq[p] && !cfgLoad) begin
        if (borrowed[p] != '0)     strobe.givePool[p] = 1'b1;
        else if (ownUsed[p] != '0) strobe.giveOwn[p]  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rrPtr <= '0;
    else if (winFound) rrPtr <= PW'(winIdx + 1'b1);
  end

endmodule

// File: rtl/sbuf_datapath.sv
module sbuf_datapath
  import sbuf_pkg::*;
#(
  parameter int POOL_SIZE = 64,
  parameter int CNT_W     = 7
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  sbStrobe_t                          strobe,
  input  logic [SB_PORTS*CNT_W-1:0]          cfgMinVec,
  input  logic [SB_PORTS*CNT_W-1:0]          cfgThrVec,
  output logic [SB_PORTS-1:0][CNT_W-1:0]     ownUsed,
  output logic [SB_PORTS-1:0][CNT_W-1:0]     borrowed,
  output logic [SB_PORTS-1:0][CNT_W-1:0]     minCnt,
  output logic [SB_PORTS-1:0][CNT_W-1:0]     thrEff,
  output logic [CNT_W-1:0]                   poolFree,
  output logic                               idle,
  output logic [SB_PORTS*CNT_W-1:0]          occupancy,
  output logic [SB_PORTS-1:0]                allocGrant,
  output logic [SB_PORTS-1:0]                allocFromPool,
  output logic [SB_PORTS-1:0]                allocDeny,
  output logic                               cfgErr
);

  localparam int NP      = SB_PORTS;
  localparam int SUM_W   = CNT_W + $clog2(NP) + 1;
  localparam int DEF_MIN = POOL_SIZE / (2 * NP);

  logic [NP-1:0][CNT_W-1:0] thrReg;
  logic [SUM_W-1:0]         sumMin;
  logic [SUM_W-1:0]         sumBor;
  logic [SUM_W-1:0]         sumOwn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NP; p++) begin
        ownUsed[p]  <= '0;
        borrowed[p] <= '0;
        minCnt[p]   <= CNT_W'(DEF_MIN);
        thrReg[p]   <= '0;
      end
    end else begin
      for (int p = 0; p < NP; p++) begin
        if (strobe.takeOwn[p])       ownUsed[p] <= ownUsed[p] + 1'b1;
        else if (strobe.giveOwn[p])  ownUsed[p] <= ownUsed[p] - 1'b1;
        if (strobe.takePool[p])      borrowed[p] <= borrowed[p] + 1'b1;
        else if (strobe.givePool[p]) borrowed[p] <= borrowed[p] - 1'b1;
        if (strobe.cfgAccept) begin
          minCnt[p] <= cfgMinVec[p*CNT_W +: CNT_W];
          thrReg[p] <= cfgThrVec[p*CNT_W +: CNT_W];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      allocGrant    <= '0;
      allocFromPool <= '0;
      allocDeny     <= '0;
      cfgErr        <= 1'b0;
    end else begin
      allocGrant    <= strobe.takeOwn | strobe.takePool;
      allocFromPool <= strobe.takePool;
      allocDeny     <= strobe.deny;
      if (strobe.cfgReject)      cfgErr <= 1'b1;
      else if (strobe.cfgAccept) cfgErr <= 1'b0;
    end
  end

  for (genvar g = 0; g < NP; g++) begin : g_view
    assign thrEff[g] = (thrReg[g] == '0) ? (minCnt[g] >> 2) : thrReg[g];
    assign occupancy[g*CNT_W +: CNT_W] = CNT_W'(ownUsed[g] + borrowed[g]);
  end

  always_comb begin
    sumMin = '0;
    sumBor = '0;
    sumOwn = '0;
    for (int p = 0; p < NP; p++) begin
      sumMin = sumMin + SUM_W'(minCnt[p]);
      sumBor = sumBor + SUM_W'(borrowed[p]);
      sumOwn = sumOwn + SUM_W'(ownUsed[p]);
    end
    poolFree = CNT_W'(SUM_W'(POOL_SIZE) - sumMin - sumBor);
    idle     = (sumBor == '0) && (sumOwn == '0);
  end

endmodule

// File: rtl/sbuf_alloc_top.sv
module sbuf_alloc_top
  import sbuf_pkg::*;
#(
  parameter  int POOL_SIZE = 64,
  localparam int CNT_W     = $clog2(POOL_SIZE + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfgLoad,
  input  logic [SB_PORTS*CNT_W-1:0] cfgMinVec,
  input  logic [SB_PORTS*CNT_W-1:0] cfgThrVec,
  input  logic [SB_PORTS-1:0]       allocReq,
  input  logic [SB_PORTS-1:0]       relReq,
  output logic [SB_PORTS-1:0]       allocGrant,
  output logic [SB_PORTS-1:0]       allocFromPool,
  output logic [SB_PORTS-1:0]       allocDeny,
  output logic [SB_PORTS*CNT_W-1:0] occupancy,
  output logic [CNT_W-1:0]          poolFree,
  output logic                      cfgErr
);

  sbStrobe_t                     strobe;
  logic [SB_PORTS-1:0][CNT_W-1:0] ownUsed;
  logic [SB_PORTS-1:0][CNT_W-1:0] borrowed;
  logic [SB_PORTS-1:0][CNT_W-1:0] minCnt;
  logic [SB_PORTS-1:0][CNT_W-1:0] thrEff;
  logic                          idle;

  sbuf_ctrl #(.POOL_SIZE(POOL_SIZE), .CNT_W(CNT_W)) ctrl_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfgLoad  (cfgLoad),
    .cfgMinVec(cfgMinVec),
    .allocReq (allocReq),
    .relReq   (relReq),
    .ownUsed  (ownUsed),
    .borrowed (borrowed),
    .minCnt   (minCnt),
    .thrEff   (thrEff),
    .poolFree (poolFree),
    .idle     (idle),
    .strobe   (strobe)
  );

  sbuf_datapath #(.POOL_SIZE(POOL_SIZE), .CNT_W(CNT_W)) dp_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .strobe       (strobe),
    .cfgMinVec    (cfgMinVec),
    .cfgThrVec    (cfgThrVec),
    .ownUsed      (ownUsed),
    .borrowed     (borrowed),
    .minCnt       (minCnt),
    .thrEff       (thrEff),
    .poolFree     (poolFree),
    .idle         (idle),
    .occupancy    (occupancy),
    .allocGrant   (allocGrant),
    .allocFromPool(allocFromPool),
    .allocDeny    (allocDeny),
    .cfgErr       (cfgErr)
  );

endmodule

// File: rtl/sbuf_alloc_chk.sv
module sbuf_alloc_chk
  import sbuf_pkg::*;
#(
  parameter  int POOL_SIZE = 64,
  localparam int CNT_W     = $clog2(POOL_SIZE + 1)
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      cfgLoad,
  input logic [SB_PORTS*CNT_W-1:0] cfgMinVec,
  input logic [SB_PORTS*CNT_W-1:0] cfgThrVec,
  input logic [SB_PORTS-1:0]       allocReq,
  input logic [SB_PORTS-1:0]       relReq,
  input logic [SB_PORTS-1:0]       allocGrant,
  input logic [SB_PORTS-1:0]       allocFromPool,
  input logic [SB_PORTS-1:0]       allocDeny,
  input logic [SB_PORTS*CNT_W-1:0] occupancy,
  input logic [CNT_W-1:0]          poolFree,
  input logic                      cfgErr
);

  // R5: one pool buffer per cycle at most
  a_r5_single_pool_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(allocFromPool) <= 1);

  // R4: a pool buffer is always also a grant
  a_r4_pool_is_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (allocFromPool & ~allocGrant) == '0);

  // R6: a request is granted or denied, never both
  a_r6_grant_deny_excl: assert property (@(posedge clk) disable iff (!rst_n)
    (allocGrant & allocDeny) == '0);

  // R7: an allocate beside a release on the same port is dropped
  a_r7_release_drops_alloc: assert property (@(posedge clk) disable iff (!rst_n)
    (|relReq) |=> (((allocGrant | allocDeny) & $past(relReq)) == '0));

  // R2: free pool level never exceeds the pool
  a_r2_pool_bound: assert property (@(posedge clk) disable iff (!rst_n)
    poolFree <= CNT_W'(POOL_SIZE));

  // R9: a strobe while busy leaves the pool level and the flag unchanged
  a_r9_busy_cfg_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgLoad && (occupancy != '0)) |=> ($stable(poolFree) && $stable(cfgErr)));

  // R10: a strobe cycle moves no buffer, and the flag only rises on a strobe
  a_r10_cfg_freezes_traffic: assert property (@(posedge clk) disable iff (!rst_n)
    cfgLoad |=> $stable(occupancy));
  a_r10_err_needs_load: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfgLoad && !cfgErr) |=> !cfgErr);

endmodule

bind sbuf_alloc_top sbuf_alloc_chk #(.POOL_SIZE(POOL_SIZE)) chk_i (.*);

// File: tb/sbuf_alloc_top_tb.sv
module sbuf_alloc_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int POOL       = 64;
  localparam int CW         = $clog2(POOL + 1);
  localparam int NP         = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            cfgLoad = 1'b0;
  logic [NP*CW-1:0] cfgMinVec = '0;
  logic [NP*CW-1:0] cfgThrVec = '0;
  logic [NP-1:0]   allocReq = '0;
  logic [NP-1:0]   relReq = '0;
  logic [NP-1:0]   allocGrant, allocFromPool, allocDeny;
  logic [NP*CW-1:0] occupancy;
  logic [CW-1:0]   poolFree;
  logic            cfgErr;

  int testsRun = 0;
  int testsFail = 0;
  bit done = 0;

  // Reference model state
  int mOwn[NP], mBor[NP], mMin[NP], mThr[NP];
  int mErr, mPtr;
  logic [NP-1:0] eG, eP, eD;

  always #(CLK_PERIOD/2) clk = ~clk;

  sbuf_alloc_top #(.POOL_SIZE(POOL)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfgLoad(cfgLoad), .cfgMinVec(cfgMinVec),
    .cfgThrVec(cfgThrVec), .allocReq(allocReq), .relReq(relReq),
    .allocGrant(allocGrant), .allocFromPool(allocFromPool), .allocDeny(allocDeny),
    .occupancy(occupancy), .poolFree(poolFree), .cfgErr(cfgErr)
  );

  task automatic chk(string tag, string what, int act, int exp);
    testsRun++;
    if (act != exp) begin
      testsFail++;
      $display("[TB] FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic int thrOf(int p);
    return (mThr[p] == 0) ? (mMin[p] / 4) : mThr[p];
  endfunction

  function automatic int expFree();
    int s = POOL;
    for (int p = 0; p < NP; p++) s = s - mMin[p] - mBor[p];
    return s;
  endfunction

  // Behavioural reference, advanced on each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < NP; p++) begin
        mOwn[p] = 0; mBor[p] = 0; mMin[p] = POOL / (2*NP); mThr[p] = 0;
      end
      mErr = 0; mPtr = 0; eG = '0; eP = '0; eD = '0;
    end else begin
      int free, win, busy, sumCfg;
      free = expFree();
      eG = '0; eP = '0; eD = '0;
      busy = 0;
      for (int p = 0; p < NP; p++) busy += mOwn[p] + mBor[p];
      if (cfgLoad) begin
        if (busy == 0) begin
          sumCfg = 0;
          for (int p = 0; p < NP; p++) sumCfg += int'(cfgMinVec[p*CW +: CW]);
          if (sumCfg > POOL) mErr = 1;
          else begin
            for (int p = 0; p < NP; p++) begin
              mMin[p] = int'(cfgMinVec[p*CW +: CW]);
              mThr[p] = int'(cfgThrVec[p*CW +: CW]);
            end
            mErr = 0;
          end
        end
      end else begin
        win = -1;
        if (free > 0) begin
          for (int i = 0; i < NP; i++) begin
            int q;
            q = (mPtr + i) % NP;
            if (win < 0 && allocReq[q] && !relReq[q] &&
                (mOwn[q] > thrOf(q) || mOwn[q] >= mMin[q])) win = q;
          end
        end
        for (int p = 0; p < NP; p++) begin
          if (relReq[p]) begin
            if (mBor[p] > 0) mBor[p]--;
            else if (mOwn[p] > 0) mOwn[p]--;
          end else if (allocReq[p]) begin
            if (p == win) begin mBor[p]++; eG[p] = 1; eP[p] = 1; end
            else if (mOwn[p] < mMin[p]) begin mOwn[p]++; eG[p] = 1; end
            else eD[p] = 1;
          end
        end
        if (win >= 0) mPtr = (win + 1) % NP;
      end
    end
  end

  // Full comparison every cycle, away from the rising edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R3", "allocGrant", int'(allocGrant), int'(eG));
      chk("R4", "allocFromPool", int'(allocFromPool), int'(eP));
      chk("R6", "allocDeny", int'(allocDeny), int'(eD));
      for (int p = 0; p < NP; p++)
        chk("R7", $sformatf("occupancy[%0d]", p), int'(occupancy[p*CW +: CW]), mOwn[p] + mBor[p]);
      chk("R2", "poolFree", int'(poolFree), expFree());
      chk("R10", "cfgErr", int'(cfgErr), mErr);
    end
  end

  task automatic step(logic [NP-1:0] a, logic [NP-1:0] r);
    allocReq = a; relReq = r;
    @(negedge clk);
    allocReq = '0; relReq = '0;
  endtask

  task automatic loadCfg(int m0, int m1, int m2, int m3, int t0, int t1, int t2, int t3);
    cfgMinVec = {CW'(m3), CW'(m2), CW'(m1), CW'(m0)};
    cfgThrVec = {CW'(t3), CW'(t2), CW'(t1), CW'(t0)};
    cfgLoad = 1'b1;
    @(negedge clk);
    cfgLoad = 1'b0;
  endtask

  task automatic drain();
    relReq = '1;
    repeat (POOL + 1) @(negedge clk);
    relReq = '0;
    @(negedge clk);
  endtask

  task automatic finishRun();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    testsFail++;
    $display("[TB] FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [NP-1:0] seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1", "poolFree", int'(poolFree), 32);
    chk("R1", "occupancy", int'(occupancy), 0);
    chk("R1", "cfgErr", int'(cfgErr), 0);
    chk("R1", "allocGrant", int'(allocGrant), 0);

    // R8 default threshold 8/4=2: reserve use 0,1,2 from reserve, then pool
    repeat (3) begin
      step(4'b0001, 4'b0000);
      chk("R3", "reserve grant", int'(allocFromPool[0]), 0);
    end
    step(4'b0001, 4'b0000);
    chk("R8", "pool after 25pct", int'(allocFromPool[0]), 1);
    chk("R2", "poolFree after borrow", int'(poolFree), 31);

    // R7: first release repays the borrowed buffer
    step(4'b0000, 4'b0001);
    chk("R7", "repay to pool", int'(poolFree), 32);
    step(4'b0001, 4'b0001);
    chk("R7", "alloc with release", int'(allocGrant[0] | allocDeny[0]), 0);

    // R9: strobe while busy is ignored
    loadCfg(0, 0, 0, 0, 0, 0, 0, 0);
    chk("R9", "busy cfg poolFree", int'(poolFree), 32);
    drain();

    // R8 explicit threshold of 5 on port 0
    loadCfg(8, 8, 8, 8, 5, 0, 0, 0);
    repeat (6) step(4'b0001, 4'b0000);
    chk("R8", "sixth from reserve", int'(allocFromPool[0]), 0);
    step(4'b0001, 4'b0000);
    chk("R8", "seventh from pool", int'(allocFromPool[0]), 1);
    drain();

    // R5: all ports over threshold, pool rotates one per cycle
    loadCfg(8, 8, 8, 8, 0, 0, 0, 0);
    repeat (3) step(4'b1111, 4'b0000);
    seen = '0;
    repeat (4) begin
      step(4'b1111, 4'b0000);
      chk("R5", "one pool grant", $countones(allocFromPool), 1);
      chk("R6", "losers on reserve", int'(allocGrant), 15);
      seen |= allocFromPool;
    end
    chk("R5", "rotation covers all", int'(seen), 15);
    drain();

    // R10: oversubscribed set rejected, valid set accepted
    loadCfg(40, 20, 10, 0, 0, 0, 0, 0);
    chk("R10", "reject flag", int'(cfgErr), 1);
    chk("R10", "old config kept", int'(poolFree), 32);
    loadCfg(16, 16, 16, 16, 0, 0, 0, 0);
    chk("R10", "flag cleared", int'(cfgErr), 0);
    chk("R10", "pool fully reserved", int'(poolFree), 0);

    // R6: empty pool, port 0 fills reserve then is denied
    repeat (16) step(4'b0001, 4'b0000);
    step(4'b0001, 4'b0000);
    chk("R6", "deny when exhausted", int'(allocDeny[0]), 1);
    chk("R6", "occupancy held", int'(occupancy[0 +: CW]), 16);
    drain();

    // Random traffic against the reference
    loadCfg(4, 8, 2, 6, 0, 3, 1, 0);
    for (int c = 0; c < 1500; c++) begin
      allocReq = NP'($urandom);
      relReq = NP'($urandom) & NP'($urandom);
      cfgLoad = ($urandom % 50) == 0;
      cfgMinVec = {CW'($urandom % 20), CW'($urandom % 20), CW'($urandom % 20), CW'($urandom % 20)};
      cfgThrVec = {CW'($urandom % 6), CW'($urandom % 6), CW'($urandom % 6), CW'($urandom % 6)};
      @(negedge clk);
    end
    allocReq = '0; relReq = '0; cfgLoad = 1'b0;
    drain();
    finishRun();
  end

endmodule